// File: doc/BRIEF.md
# Strobed-Select Parallel Memory Sequencer

This block sits between a synchronous host and an external bytewide nonvolatile memory. That memory begins each cycle on a falling chip-select edge, latches the address on that edge, and needs a chip-select-high recovery interval before the next cycle can start. The host sends one request at a time on a valid/ready port. Each request carries an address, a write byte and a direction bit. For every request the block produces exactly one chip-select strobe. Reads return one response pulse that carries the sampled byte.

All bus timing is counted in clock cycles. `ACT_CYC` is the number of cycles chip-select stays low; it covers the access time and the write-data setup. `PC_CYC` is the number of high cycles that form the recovery interval. `HOLD_CYC` is the address hold after the falling edge. `PWRUP_CYC` is the start-up wait that follows reset. With a 100 MHz clock the defaults are 7, 6, 2 and 1,000,000 cycles, which is 10 ms. All writes are select-controlled: write-enable falls together with chip-select and rises together with it. The host data driver is enabled only while a write strobe is low.

The controller is a four-state machine:
- `ST_PWRUP` is the start-up wait. Both strobes are held high and the port is not ready. When the wait counter expires, the machine moves to `ST_IDLE`.
- `ST_IDLE` is the only ready state. An offered request is accepted and the machine moves to `ST_ACCESS`.
- `ST_ACCESS` holds chip-select low for `ACT_CYC` cycles. When it expires, the machine moves to `ST_PRECHG`.
- `ST_PRECHG` holds chip-select high for `PC_CYC` cycles. When it expires, the machine returns to `ST_IDLE`.

Top module: `strobe_mem_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly `PWRUP_CYC` cycles and then goes high. During reset and during that wait, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0. A request offered during the wait is not accepted.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the recovery interval of that access has finished.
- R3: In the cycle after acceptance, `mem_ce_n` goes to 0. It stays 0 for exactly `ACT_CYC` consecutive cycles.
- R4: After `mem_ce_n` rises, it stays 1 for exactly `PC_CYC` cycles before `req_ready` returns. It never falls again with fewer than `PC_CYC` high cycles behind it.
- R5: `mem_addr` equals the accepted address from the first low cycle of `mem_ce_n`. It does not change while `mem_ce_n` is 0, and in particular not within the first `HOLD_CYC` cycles after the falling edge.
- R6: For a write (`req_write`=1), `mem_we_n` is 0 in exactly the cycles where `mem_ce_n` is 0, and `mem_oe_n` stays 1. `mem_we_n` is never 0 while `mem_ce_n` is 1.
- R7: For a write, `mem_dq_oe` is 1 and `mem_dq_o` equals the accepted byte in exactly the low cycles of `mem_ce_n`. `mem_dq_oe` is 0 in all other cycles.
- R8: For a read (`req_write`=0), `mem_oe_n` is 0 in exactly the low cycles of `mem_ce_n`, and `mem_dq_oe` stays 0.
- R9: A read produces a one-cycle `rsp_valid` pulse in the cycle right after the last low cycle of `mem_ce_n`. `rsp_rdata` carries the value that `mem_dq_i` had in that last low cycle. A write produces no pulse.
- R10: Consecutive requests, including repeated reads of one address, each produce their own falling edge of `mem_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the start-up wait |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Byte sampled from the memory |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable to the memory, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the host data driver |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
A wrong state or a wrong counter value shows at the strobes at once. A chip-select low time that is one cycle short or long appears at the edge where `mem_ce_n` rises. A shortened recovery interval appears as an early `req_ready` in the very next cycle. A missed direction bit flips `mem_we_n` or `mem_oe_n` in the first low cycle. A sample taken too early is caught because the bench memory only presents valid data from the final low cycle, so `rsp_rdata` is wrong on the response pulse. A dropped write shows up at the next read of the same address.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        ST_PWRUP  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_PRECHG = 2'd3
    } mc_state_e;
endpackage

// File: rtl/mc_phase_timer.sv
module mc_phase_timer #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mc_req_latch.sv
module mc_req_latch #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            wr_q   <= wr_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/mc_data_path.sv
module mc_data_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    assign dq_o  = wdata;
    assign dq_oe = drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= dq_i;
            end
        end
    end
endmodule

// File: rtl/strobe_mem_ctrl.sv
module strobe_mem_ctrl
    import mc_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int ACT_CYC   = 7,
    parameter int PC_CYC    = 6,
    parameter int HOLD_CYC  = 2,
    parameter int PWRUP_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int MAX_AP  = (ACT_CYC > PC_CYC) ? ACT_CYC : PC_CYC;
    localparam int MAX_ALL = (PWRUP_CYC > MAX_AP) ? PWRUP_CYC : MAX_AP;
    localparam int TW      = (MAX_ALL < 2) ? 1 : $clog2(MAX_ALL + 1);
    localparam int CW      = $clog2(ACT_CYC + PC_CYC + HOLD_CYC + 2);

    mc_state_e          state_q, state_d;
    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_done;
    logic               accept;
    logic               wr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               drive;
    logic               capture;

    mc_phase_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    mc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (accept),
        .wr_in   (req_write),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .wr_q    (wr_q),
        .addr_q  (mem_addr),
        .data_q  (wdata_q)
    );

    mc_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive     (drive),
        .capture   (capture),
        .wdata     (wdata_q),
        .dq_i      (mem_dq_i),
        .dq_o      (mem_dq_o),
        .dq_oe     (mem_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        unique case (state_q)
            ST_PWRUP: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    state_d  = ST_ACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ACT_CYC - 1);
                end
            end
            ST_ACCESS: begin
                if (tmr_done) begin
                    state_d  = ST_PRECHG;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PC_CYC - 1);
                end
            end
            ST_PRECHG: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_PWRUP;
        endcase
    end

    // Strobes decoded from the state
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        drive     = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_PWRUP:  ;
            ST_IDLE:   req_ready = 1'b1;
            ST_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_we_n = !wr_q;
                mem_oe_n = wr_q;
                drive    = wr_q;
                capture  = !wr_q && tmr_done;
            end
            ST_PRECHG: ;
            default:   ;
        endcase
    end

    // Bus-timing checks
    logic [CW-1:0] lo_cnt, hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else if (!mem_ce_n) begin
            hi_cnt <= '0;
            if (lo_cnt != CW'(ACT_CYC + HOLD_CYC + 1)) lo_cnt <= lo_cnt + 1'b1;
        end else begin
            lo_cnt <= '0;
            if (hi_cnt != CW'(PC_CYC + 1)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));
    assert_ce_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (lo_cnt == CW'(ACT_CYC)));
    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (hi_cnt >= CW'(PC_CYC)));
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && lo_cnt != '0 && lo_cnt <= CW'(HOLD_CYC)) |-> $stable(mem_addr));
    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && lo_cnt != '0) |-> $stable(mem_addr));
    assert_we_inside_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
    assert_drive_only_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));
    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);
    assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($rose(mem_ce_n) && !$past(mem_oe_n)));
endmodule

// File: tb/strobe_mem_ctrl_tb.sv
`timescale 1ns/1ps
module strobe_mem_ctrl_tb;
    localparam int AW  = 13;
    localparam int DW  = 8;
    localparam int ACT = 7;
    localparam int PC  = 6;
    localparam int PWR = 40;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [3:0]    gap;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    always #4 clk = ~clk;

    strobe_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACT_CYC(ACT), .PC_CYC(PC),
                      .HOLD_CYC(2), .PWRUP_CYC(PWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

    // Device model: data valid only from the final low cycle of an access
    logic [DW-1:0] dev_mem [0:(1<<AW)-1];
    int low_cyc = 0;
    always @(posedge clk) begin
        if (mem_ce_n) low_cyc <= 0;
        else          low_cyc <= low_cyc + 1;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) dev_mem[mem_addr] <= mem_dq_o;
    end
    assign mem_dq_i = (!mem_ce_n && !mem_oe_n && low_cyc >= ACT - 1) ? dev_mem[mem_addr] : 8'hEE;

    // Reference model
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    int m_phase, m_cnt;
    logic m_wr, m_rsp;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, m_rdata;
    req_t rq[$];
    int gap_left;
    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2 req_ready", 32'(req_ready), 32'(m_phase == 1));
        chk("R3/R4/R10 mem_ce_n", 32'(mem_ce_n), 32'(m_phase != 2));
        chk("R6 mem_we_n", 32'(mem_we_n), 32'(!(m_phase == 2 && m_wr)));
        chk("R8 mem_oe_n", 32'(mem_oe_n), 32'(!(m_phase == 2 && !m_wr)));
        chk("R7 mem_dq_oe", 32'(mem_dq_oe), 32'(m_phase == 2 && m_wr));
        chk("R9 rsp_valid", 32'(rsp_valid), 32'(m_rsp));
        if (m_phase == 2) chk("R5 mem_addr", 32'(mem_addr), 32'(m_addr));
        if (m_phase == 2 && m_wr) chk("R7 mem_dq_o", 32'(mem_dq_o), 32'(m_wdata));
        if (m_rsp) chk("R9 rsp_rdata", 32'(rsp_rdata), 32'(m_rdata));
    endtask

    task automatic model_step();
        m_rsp = 1'b0;
        case (m_phase)
            0: if (m_cnt == PWR - 1) begin m_phase = 1; m_cnt = 0; end else m_cnt++;
            1: if (req_valid) begin
                m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
                m_phase = 2; m_cnt = 0;
                void'(rq.pop_front());
                gap_left = (rq.size() != 0) ? int'(rq[0].gap) : 0;
            end
            2: if (m_cnt == ACT - 1) begin
                m_phase = 3; m_cnt = 0;
                if (m_wr) ref_mem[m_addr] = m_wdata;
                else begin m_rsp = 1'b1; m_rdata = ref_mem[m_addr]; end
            end else m_cnt++;
            default: if (m_cnt == PC - 1) begin m_phase = 1; m_cnt = 0; end else m_cnt++;
        endcase
    endtask

    function automatic req_t mk(input logic wr, input int a, input int d, input int g);
        req_t r;
        r.wr = wr; r.a = AW'(a); r.d = DW'(d); r.gap = 4'(g);
        return r;
    endfunction

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            dev_mem[i] = DW'((i * 7 + 3) ^ (i >> 8));
            ref_mem[i] = DW'((i * 7 + 3) ^ (i >> 8));
        end
        // R1: request offered from time zero, during the start-up wait
        rq.push_back(mk(1, 0, 8'h5A, 0));
        rq.push_back(mk(1, 8191, 8'hA5, 0));
        rq.push_back(mk(0, 0, 0, 0));
        rq.push_back(mk(0, 8191, 0, 2));
        rq.push_back(mk(0, 100, 0, 0));
        rq.push_back(mk(0, 100, 0, 0));     // R10: same address back to back
        rq.push_back(mk(0, 101, 0, 0));     // R10: sequential address
        rq.push_back(mk(1, 100, 8'h3C, 3));
        rq.push_back(mk(0, 100, 0, 0));
        for (int i = 0; i < 24; i++)
            rq.push_back(mk(i % 3 != 2, (i * 613 + 17) % 8192, i * 29 + 1, i % 4));
        for (int i = 0; i < 24; i++)
            rq.push_back(mk(0, (i * 613 + 17) % 8192, 0, i % 2));
        m_phase = 0; m_cnt = 0; m_wr = 0; m_rsp = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
        gap_left = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset ce_n", 32'(mem_ce_n), 32'd1);
        chk("R1 reset we_n", 32'(mem_we_n), 32'd1);
        chk("R1 reset oe_n", 32'(mem_oe_n), 32'd1);
        chk("R1 reset ready", 32'(req_ready), 32'd0);
        chk("R1 reset dq_oe", 32'(mem_dq_oe), 32'd0);
        rst_n = 1'b1;

        for (int cyc = 0; ; cyc++) begin
            if (cyc > 20000) begin
                n_bad++; n_cmp++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
                break;
            end
            compare_all();
            if (rq.size() == 0 && m_phase == 1) break;
            if (rq.size() != 0 && gap_left == 0) begin
                req_valid = 1'b1; req_write = rq[0].wr; req_addr = rq[0].a; req_wdata = rq[0].d;
            end else begin
                req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
                if (gap_left > 0 && m_phase == 1) gap_left--;
            end
            model_step();
            @(posedge clk);
            @(negedge clk);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule